// File: doc/BRIEF.md
# Trace Capture Controller with Delta Encoding

The block takes a stream of trace words that have already been sampled from a system bus and writes them into a circular on-chip trace memory. Each stored entry is a word with a 2-bit tag in its top bits. In most entries the payload is the modular difference between the incoming word and the previously stored word. At regular, configurable intervals the controller stores the raw word instead, as a reference. When the resolution mode changes during capture, a marker entry is placed in the stream. Because of the references, a decoder can resynchronise after the oldest part of the buffer has been overwritten.

Two capture directions are supported. In post-trigger mode the controller waits in an armed state until a word matches either of two compare values. It stores that word as the first reference and stops once every memory slot has been written. In pre-trigger mode capture begins one cycle after reset or re-arm. The write pointer then wraps over the oldest entries, and capture freezes after the matching word has been stored. Readout is done by logical index. The block maps index 0 onto the oldest surviving entry and returns the physical address to the host.

The state machine has three states: ARMED, CAPTURE and DONE. Its transitions are REARM (any state to ARMED on `arm`), PRE_START (ARMED to CAPTURE in pre-trigger mode, without a write), POST_START (ARMED to CAPTURE on a match in post-trigger mode, with the matching word written), FILL_STOP (CAPTURE to DONE when the last slot is written in post-trigger mode) and MATCH_STOP (CAPTURE to DONE when the matching word is written in pre-trigger mode).

Top module: `trace_capture_ctrl`

## Requirements
- R1: After reset with post-trigger mode selected, the controller is armed, reports a count of 0 and writes nothing while incoming words fail to match.
- R2: In the armed post-trigger state, a valid word equal to an enabled compare value (either A or B) is written at address 0 with tag 01 and the raw word as payload.
- R3: A data entry that is not a reference has tag 00 and payload (word - previous stored data word) mod 2^DATA_W. Tag 11 is never written.
- R4: With period N, data entries 0, N, 2N, ... counted from capture start or from the last marker have tag 01 and the raw word. A period of 0 acts as 1.
- R5: In post-trigger mode, capture stops after DEPTH entries: done is set, the count is DEPTH, and later words (matching ones included) write nothing. A match during capture is stored as ordinary data.
- R6: In pre-trigger mode, capture begins on the cycle after reset or re-arm without any match. Writes continue past the last address back to address 0, and the wrapped flag is set.
- R7: In pre-trigger mode, a matching word is stored as the final entry and the controller enters DONE. The readout address is (write pointer + index) mod DEPTH if wrapped, and the index itself otherwise.
- R8: A change of the resolution mode during capture writes a marker entry (tag 10, payload = new mode) on the first following cycle that has no valid word. The next data entry after the marker is a reference.
- R9: A pulse on `arm` returns the controller to ARMED from any state, clears pointer, count and wrapped flag, and suppresses any write in that cycle.
- R10: The status outputs report armed, capturing and done from the state. The count rises by one per write and saturates at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pre_mode | input | 1 | 1 = pre-trigger direction, 0 = post-trigger |
| arm | input | 1 | Re-arm pulse |
| cfg_ref_period | input | PER_W (8) | Reference interval N in data entries |
| cfg_evt_a | input | DATA_W (16) | Compare value A |
| cfg_evt_a_en | input | 1 | Enable for compare A |
| cfg_evt_b | input | DATA_W (16) | Compare value B |
| cfg_evt_b_en | input | 1 | Enable for compare B |
| cfg_res_mode | input | MODE_W (2) | Current trace resolution mode |
| in_valid | input | 1 | Trace word valid |
| in_data | input | DATA_W (16) | Trace word |
| mem_we | output | 1 | Trace memory write enable |
| mem_waddr | output | ADDR_W (6) | Trace memory write address |
| mem_wdata | output | DATA_W+2 (18) | {tag, payload} |
| rd_idx | input | ADDR_W (6) | Logical readout index, 0 = oldest |
| rd_addr | output | ADDR_W (6) | Physical address for rd_idx |
| st_armed | output | 1 | In ARMED |
| st_capturing | output | 1 | In CAPTURE |
| st_done | output | 1 | In DONE |
| st_wrapped | output | 1 | Pointer has wrapped in pre-trigger capture |
| st_count | output | ADDR_W+1 (7) | Number of valid entries |

## Verification
A mode change and a valid trace word can arrive in the same cycle. The bench provokes this by changing the mode while words arrive back to back. It then checks that the word is stored as a difference, that the marker waits for the first idle cycle, and that the entry after the marker is a reference. A second collision is a compare match on a word during post-trigger capture. The bench places such a word mid-stream and checks that it is stored as plain difference data and does not disturb the fill stop.

// File: rtl/trc_pkg.sv
package trc_pkg;
    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_DONE    = 2'd2
    } trc_state_e;

    typedef enum logic [1:0] {
        TAG_DIFF = 2'b00,
        TAG_REF  = 2'b01,
        TAG_MARK = 2'b10,
        TAG_RSVD = 2'b11
    } trc_tag_e;
endpackage

// File: rtl/trc_event_match.sv
module trc_event_match #(
    parameter int DATA_W  = 16,
    parameter int NUM_EVT = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            word_valid,
    input  logic [DATA_W-1:0]               word,
    input  logic [NUM_EVT-1:0][DATA_W-1:0]  cmp_val,
    input  logic [NUM_EVT-1:0]              cmp_en,
    output logic                            hit
);
    logic [NUM_EVT-1:0] hit_vec;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_cmp
        assign hit_vec[g] = word_valid && cmp_en[g] && (word == cmp_val[g]);
    end

    assign hit = |hit_vec;

    // R2: a match is only reported on a valid word
    assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> word_valid);
endmodule

// File: rtl/trc_delta_enc.sv
module trc_delta_enc
    import trc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PER_W  = 8,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              data_we,
    input  logic              mark_we,
    input  logic [PER_W-1:0]  period,
    input  logic [DATA_W-1:0] in_data,
    input  logic [MODE_W-1:0] mode_val,
    output logic [1:0]        tag,
    output logic [DATA_W-1:0] payload
);
    logic [DATA_W-1:0] prev_q;
    logic [PER_W-1:0]  ref_cnt_q;
    logic [PER_W:0]    ref_nxt;
    trc_tag_e          tag_e;

    assign ref_nxt = {1'b0, ref_cnt_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev_q    <= '0;
            ref_cnt_q <= '0;
        end else if (mark_we) begin
            ref_cnt_q <= '0;
        end else if (data_we) begin
            prev_q    <= in_data;
            ref_cnt_q <= (ref_nxt >= {1'b0, period}) ? '0 : ref_nxt[PER_W-1:0];
        end
    end

    always_comb begin
        if (mark_we) begin
            tag_e   = TAG_MARK;
            payload = DATA_W'(mode_val);
        end else if (ref_cnt_q == '0) begin
            tag_e   = TAG_REF;
            payload = in_data;
        end else begin
            tag_e   = TAG_DIFF;
            payload = in_data - prev_q;
        end
    end

    assign tag = tag_e;

    // R3: the reserved code never reaches memory
    assert_no_reserved_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we || mark_we) |-> (tag != TAG_RSVD));
endmodule

// File: rtl/trc_wr_ptr.sv
module trc_wr_ptr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              we,
    input  logic              pre_mode,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   cnt,
    output logic              wrapped,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0]   FULL_CNT = (ADDR_W+1)'(DEPTH);
    localparam logic [ADDR_W-1:0] LAST_AD  = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] wptr_q;
    logic [ADDR_W:0]   cnt_q;
    logic              wrap_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr_q <= '0;
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else if (we) begin
            wptr_q <= wptr_q + 1'b1;
            if (cnt_q != FULL_CNT) cnt_q <= cnt_q + 1'b1;
            if (pre_mode && wptr_q == LAST_AD) wrap_q <= 1'b1;
        end
    end

    assign waddr   = wptr_q;
    assign cnt     = cnt_q;
    assign wrapped = wrap_q;
    assign rd_addr = wrap_q ? (wptr_q + rd_idx) : rd_idx;

    // R6: wrap of the pointer in pre-trigger capture raises the flag
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clear && pre_mode && wptr_q == LAST_AD) |=> (wptr_q == '0 && wrap_q));
    // R10: count steps by one per write below saturation
    assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clear && cnt_q != FULL_CNT) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R10: count never exceeds the depth
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
    import trc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6,
    parameter int PER_W  = 8,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pre_mode,
    input  logic              arm,
    input  logic [PER_W-1:0]  cfg_ref_period,
    input  logic [DATA_W-1:0] cfg_evt_a,
    input  logic              cfg_evt_a_en,
    input  logic [DATA_W-1:0] cfg_evt_b,
    input  logic              cfg_evt_b_en,
    input  logic [MODE_W-1:0] cfg_res_mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W+1:0] mem_wdata,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              st_armed,
    output logic              st_capturing,
    output logic              st_done,
    output logic              st_wrapped,
    output logic [ADDR_W:0]   st_count
);
    localparam int NUM_EVT = 2;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam logic [ADDR_W:0] LAST_CNT = (ADDR_W+1)'(DEPTH - 1);

    trc_state_e        state_q, state_d;
    logic              trig, data_we, mark_we, mark_pend_q;
    logic [MODE_W-1:0] mode_q;
    logic [1:0]        tag;
    logic [DATA_W-1:0] payload;
    logic [NUM_EVT-1:0][DATA_W-1:0] cmp_val;

    assign cmp_val = {cfg_evt_b, cfg_evt_a};

    trc_event_match #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) u_match (
        .clk(clk), .rst_n(rst_n), .word_valid(in_valid), .word(in_data),
        .cmp_val(cmp_val), .cmp_en({cfg_evt_b_en, cfg_evt_a_en}), .hit(trig)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // Next state: REARM, PRE_START, POST_START, FILL_STOP, MATCH_STOP
    always_comb begin
        state_d = state_q;
        if (arm) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_ARMED: begin
                    if (cfg_pre_mode || trig) state_d = ST_CAPTURE;
                end
                ST_CAPTURE: begin
                    if (cfg_pre_mode && trig)
                        state_d = ST_DONE;
                    else if (!cfg_pre_mode && mem_we && st_count == LAST_CNT)
                        state_d = ST_DONE;
                end
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_ARMED;
            endcase
        end
    end

    // Output decode
    always_comb begin
        data_we = 1'b0;
        mark_we = 1'b0;
        if (!arm) begin
            unique case (state_q)
                ST_ARMED:   data_we = !cfg_pre_mode && trig;
                ST_CAPTURE: begin
                    data_we = in_valid;
                    mark_we = !in_valid && mark_pend_q;
                end
                default: ;
            endcase
        end
    end

    // Pending mode-change marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= '0;
            mark_pend_q <= 1'b0;
        end else begin
            mode_q <= cfg_res_mode;
            if (arm || mark_we)
                mark_pend_q <= 1'b0;
            else if (state_q == ST_CAPTURE && cfg_res_mode != mode_q)
                mark_pend_q <= 1'b1;
        end
    end

    trc_delta_enc #(.DATA_W(DATA_W), .PER_W(PER_W), .MODE_W(MODE_W)) u_enc (
        .clk(clk), .rst_n(rst_n), .clear(arm), .data_we(data_we), .mark_we(mark_we),
        .period(cfg_ref_period), .in_data(in_data), .mode_val(cfg_res_mode),
        .tag(tag), .payload(payload)
    );

    trc_wr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clear(arm), .we(mem_we), .pre_mode(cfg_pre_mode),
        .rd_idx(rd_idx), .waddr(mem_waddr), .cnt(st_count), .wrapped(st_wrapped),
        .rd_addr(rd_addr)
    );

    assign mem_we       = data_we || mark_we;
    assign mem_wdata    = {tag, payload};
    assign st_armed     = (state_q == ST_ARMED);
    assign st_capturing = (state_q == ST_CAPTURE);
    assign st_done      = (state_q == ST_DONE);

    // R5: nothing is written once capture has finished
    assert_done_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> !mem_we);
    // R7: a match in pre-trigger capture ends the run
    assert_pre_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE && cfg_pre_mode && trig && !arm) |=> (state_q == ST_DONE));
    // R8: the entry after a marker is never a difference
    assert_marker_then_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_wdata[DATA_W+1:DATA_W] == TAG_MARK)
        |=> !(mem_we && mem_wdata[DATA_W+1:DATA_W] == TAG_DIFF));
    // R9: re-arm suppresses writing
    assert_arm_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !mem_we);
endmodule

// File: tb/trace_capture_ctrl_bench.sv
module trace_capture_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pre_mode = 1'b0, arm = 1'b0;
    logic [7:0]  cfg_ref_period = 8'd64;
    logic [15:0] cfg_evt_a = 16'hAAAA, cfg_evt_b = 16'h1234;
    logic        cfg_evt_a_en = 1'b1, cfg_evt_b_en = 1'b1;
    logic [1:0]  cfg_res_mode = 2'd0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        mem_we;
    logic [5:0]  mem_waddr, rd_idx = '0, rd_addr;
    logic [17:0] mem_wdata;
    logic        st_armed, st_capturing, st_done, st_wrapped;
    logic [6:0]  st_count;

    int tests = 0, fails = 0, wr_count = 0;
    logic [17:0] mem [64];

    always #2 clk = ~clk;

    trace_capture_ctrl u_trace_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_pre_mode(cfg_pre_mode), .arm(arm),
        .cfg_ref_period(cfg_ref_period), .cfg_evt_a(cfg_evt_a), .cfg_evt_a_en(cfg_evt_a_en),
        .cfg_evt_b(cfg_evt_b), .cfg_evt_b_en(cfg_evt_b_en), .cfg_res_mode(cfg_res_mode),
        .in_valid(in_valid), .in_data(in_data), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .rd_idx(rd_idx), .rd_addr(rd_addr), .st_armed(st_armed),
        .st_capturing(st_capturing), .st_done(st_done), .st_wrapped(st_wrapped),
        .st_count(st_count)
    );

    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            mem[mem_waddr] <= mem_wdata;
            wr_count = wr_count + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] d);
        in_valid = v;
        in_data  = d;
        @(negedge clk);
    endtask

    task automatic do_arm();
        arm = 1'b1;
        step(1'b0, '0);
        arm = 1'b0;
    endtask

    function automatic logic [15:0] wv(int i);
        if (i == 0)  return 16'h1234;
        if (i == 10) return 16'hAAAA;
        return 16'(i * 37) ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] pv(int i);
        return 16'(i * 3 + 7);
    endfunction

    task automatic t_reset();
        int w0;
        w0 = wr_count;
        chk("R1 armed", 32'(st_armed), 1);
        chk("R1 count", 32'(st_count), 0);
        step(1'b1, 16'h0001);
        step(1'b1, 16'h0002);
        chk("R1 no write before match", 32'(wr_count - w0), 0);
    endtask

    task automatic t_post();
        int w0;
        cfg_ref_period = 8'd4;
        do_arm();
        step(1'b1, 16'h0101);
        chk("R5 idle before match", 32'(st_armed), 1);
        for (int i = 0; i < 64; i++) begin
            if (i % 7 == 3) step(1'b0, 16'hAAAA);
            step(1'b1, wv(i));
        end
        chk("R5 done", 32'(st_done), 1);
        chk("R5 count", 32'(st_count), 64);
        chk("R5 not wrapped", 32'(st_wrapped), 0);
        chk("R2 first entry", 32'(mem[0]), 32'({2'b01, 16'h1234}));
        for (int i = 1; i < 64; i++) begin
            if (i % 4 == 0) chk("R4 reference", 32'(mem[i]), 32'({2'b01, wv(i)}));
            else chk("R3 difference", 32'(mem[i]), 32'({2'b00, 16'(wv(i) - wv(i-1))}));
        end
        w0 = wr_count;
        step(1'b1, 16'h1234);
        step(1'b1, 16'hAAAA);
        step(1'b1, 16'h7777);
        chk("R5 silent after done", 32'(wr_count - w0), 0);
        chk("R5 still done", 32'(st_done), 1);
    endtask

    task automatic t_pre_wrap();
        cfg_pre_mode = 1'b1;
        cfg_ref_period = 8'd8;
        cfg_evt_a = 16'hBEEF;
        cfg_evt_b_en = 1'b0;
        do_arm();
        chk("R9 armed after arm", 32'(st_armed), 1);
        chk("R9 count cleared", 32'(st_count), 0);
        step(1'b0, '0);
        chk("R6 capturing without match", 32'(st_capturing), 1);
        for (int i = 0; i < 100; i++) step(1'b1, pv(i));
        chk("R6 still capturing", 32'(st_capturing), 1);
        step(1'b1, 16'hBEEF);
        chk("R7 done", 32'(st_done), 1);
        chk("R6 wrapped", 32'(st_wrapped), 1);
        chk("R10 count saturates", 32'(st_count), 64);
        rd_idx = 6'd0; #1;
        chk("R7 oldest address", 32'(rd_addr), 37);
        rd_idx = 6'd63; #1;
        chk("R7 newest address", 32'(rd_addr), 36);
        chk("R7 final entry", 32'(mem[36]), 32'({2'b00, 16'(16'hBEEF - pv(99))}));
        chk("R3 oldest entry", 32'(mem[37]), 32'({2'b00, 16'd3}));
        chk("R4 reference 40", 32'(mem[40]), 32'({2'b01, pv(40)}));
        chk("R6 overwritten slot 0", 32'(mem[0]), 32'({2'b01, pv(64)}));
        do_arm();
        chk("R9 wrapped cleared", 32'(st_wrapped), 0);
    endtask

    task automatic t_pre_short();
        cfg_evt_b = 16'hC0DE;
        cfg_evt_b_en = 1'b1;
        step(1'b0, '0);
        for (int i = 0; i < 5; i++) step(1'b1, 16'h0100 + 16'(i));
        step(1'b1, 16'hC0DE);
        chk("R7 done on compare B", 32'(st_done), 1);
        chk("R7 not wrapped", 32'(st_wrapped), 0);
        chk("R10 count", 32'(st_count), 6);
        rd_idx = 6'd2; #1;
        chk("R7 direct address", 32'(rd_addr), 2);
        chk("R7 last entry", 32'(mem[5]), 32'({2'b00, 16'(16'hC0DE - 16'h0104)}));
        chk("R4 first reference", 32'(mem[0]), 32'({2'b01, 16'h0100}));
    endtask

    task automatic t_mode();
        cfg_pre_mode = 1'b0;
        cfg_ref_period = 8'd64;
        cfg_evt_b = 16'h1234;
        do_arm();
        step(1'b1, 16'h1234);
        step(1'b1, 16'h1240);
        step(1'b1, 16'h1250);
        cfg_res_mode = 2'd2;
        step(1'b1, 16'h1255);
        step(1'b0, 16'h0000);
        step(1'b1, 16'h2000);
        step(1'b1, 16'h2003);
        chk("R8 count", 32'(st_count), 7);
        chk("R3 word in change cycle", 32'(mem[3]), 32'({2'b00, 16'h0005}));
        chk("R8 marker", 32'(mem[4]), 32'({2'b10, 16'h0002}));
        chk("R8 reference after marker", 32'(mem[5]), 32'({2'b01, 16'h2000}));
        chk("R3 diff after reference", 32'(mem[6]), 32'({2'b00, 16'h0003}));
        cfg_res_mode = 2'd3;
        step(1'b1, 16'h2010);
        step(1'b1, 16'h2020);
        step(1'b0, 16'h0000);
        step(1'b1, 16'h2100);
        chk("R8 deferred data", 32'(mem[8]), 32'({2'b00, 16'h0010}));
        chk("R8 second marker", 32'(mem[9]), 32'({2'b10, 16'h0003}));
        chk("R8 second reference", 32'(mem[10]), 32'({2'b01, 16'h2100}));
        do_arm();
        chk("R9 arm during capture", 32'(st_armed), 1);
        chk("R9 count cleared mid-run", 32'(st_count), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_post();
        t_pre_wrap();
        t_pre_short();
        t_mode();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule